// File: doc/BRIEF.md
# Horizontal Line Timing Generator

This block produces the per-line timing for a simple raster display. A free-running 9-bit pixel-clock counter, stepped by a 10 MHz clock (100 ns per step), runs through 300 states (0 to 299) and wraps. This gives a 30.0 µs line. Every output is decoded from the counter value in the same cycle, so each output edge lines up exactly with the count that defines it.

There are four outputs:
- A 2 µs horizontal sync pulse, which marks the start of a new line.
- A one-clock strobe that tells a separate vertical counter to advance. That counter changes state only on clocks where the strobe is high.
- A 128-clock visible-region window.
- A 7-bit pixel address that selects picture elements while the window is open.

The vertical counter, the pixel data path and colour generation are outside this block.

Top module: `hline_timing`

## Requirements
- R1: The internal count advances by one on every rising clock edge outside reset, runs 0 to 299 and then returns to 0, so every output repeats with a period of exactly 300 clocks.
- R2: The reset is synchronous and active low. On a rising edge with `rst_n` low the count becomes 0. While reset is held, `line_sync`, `vadv_stb` and `vis_win` are 0 and `pix_addr` is 0. On the first edge after release the count becomes 1.
- R3: `line_sync` is 1 for counts 1 through 20 inclusive (20 clocks, 2 µs) and 0 for every other count.
- R4: `vadv_stb` is 1 only when the count equals 6. It is a single-clock pulse and occurs exactly once per line, 5 clocks (500 ns) after `line_sync` rises.
- R5: `vis_win` is 1 for counts 128 through 255 inclusive (128 clocks, 12.8 µs) and 0 otherwise. It rises 127 clocks after `line_sync` rises.
- R6: `pix_addr` equals the low 7 bits of the count on every clock. It reads 0 on the first clock of `vis_win` and 127 on its last clock.
- R7: The vertical-advance strobe falls inside the sync pulse, so `line_sync` and `vadv_stb` are both 1 in the same clock at count 6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 10 MHz pixel clock |
| rst_n | input | 1 | Synchronous reset, active low |
| line_sync | output | 1 | Horizontal sync pulse, counts 1 to 20 |
| vadv_stb | output | 1 | One-clock vertical-advance strobe at count 6 |
| vis_win | output | 1 | Visible-region window, counts 128 to 255 |
| pix_addr | output | 7 | Pixel address, the low 7 bits of the count |

## Verification
The sync pulse and the vertical-advance strobe overlap at count 6. A dedicated scenario waits for that clock and requires both outputs high at once. It then checks that the strobe is low on the clocks before and after it while sync stays high. A reset applied in the middle of the visible window provokes a second collision, between restart and an open window. That case is judged by the window closing on the reset edge and by sync reappearing one clock after release.

// File: rtl/hline_pkg.sv
// Package hline_pkg
// Shared types for the horizontal line timing generator.
// Assumes: one pixel clock domain, outputs decoded combinationally.
package hline_pkg;

    // Decoded per-clock timing flags
    typedef struct packed {
        logic sync;
        logic stb;
        logic vis;
    } line_flags_t;

endpackage

// File: rtl/hline_counter.sv
// Module hline_counter
// Free-running line position counter: 0 .. LINE_LEN-1, then back to 0.
// Assumes: synchronous active-low reset, LINE_LEN <= 2**CNT_W.
module hline_counter #(
    parameter int CNT_W    = 9,
    parameter int LINE_LEN = 300
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic [CNT_W-1:0] cnt
);

    localparam logic [CNT_W-1:0] LAST_V = CNT_W'(LINE_LEN - 1);

    logic [CNT_W-1:0] cnt_q;

    // Step the count each clock and wrap at the end of the line
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (cnt_q == LAST_V) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign cnt = cnt_q;

    AST_WRAP_TO_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q == LAST_V) |=> (cnt_q == '0)); // R1
    AST_NEVER_PAST_END: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q != LAST_V) |=> (cnt_q != '0)); // R1
    AST_RST_CLEARS: assert property (@(posedge clk)
        (!rst_n) |=> (cnt_q == '0)); // R2

endmodule

// File: rtl/hline_window.sv
// Module hline_window
// Flags counts in the inclusive range FIRST..LAST.
// The range shape picks the comparator variant.
// Assumes: FIRST <= LAST < 2**CNT_W.
module hline_window #(
    parameter int CNT_W = 9,
    parameter int FIRST = 1,
    parameter int LAST  = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] cnt,
    output logic             hit
);

    localparam logic [CNT_W-1:0] FIRST_V = CNT_W'(FIRST);
    localparam logic [CNT_W-1:0] LAST_V  = CNT_W'(LAST);

    generate
        if (FIRST == LAST) begin : g_point
            // Single-count strobe: equality compare
            always_comb hit = (cnt == FIRST_V);
        end else if (FIRST == 0) begin : g_from_zero
            // Range starting at zero: upper bound only
            always_comb hit = (cnt <= LAST_V);
        end else begin : g_range
            // General range: both bounds
            always_comb hit = (cnt >= FIRST_V) && (cnt <= LAST_V);
        end
    endgenerate

    AST_WIN_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hit) |-> (cnt == FIRST_V)); // R3, R4, R5
    AST_WIN_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(hit) |-> ($past(cnt) == LAST_V)); // R3, R4, R5

endmodule

// File: rtl/hline_timing.sv
// Module hline_timing
// Top of the horizontal line timing generator.
// Combines the line counter with three window decoders and exposes the
// pixel address as the low counter bits.
// Assumes: 10 MHz pixel clock, synchronous active-low reset.
module hline_timing #(
    parameter int CNT_W      = 9,
    parameter int ADDR_W     = 7,
    parameter int LINE_LEN   = 300,
    parameter int SYNC_FIRST = 1,
    parameter int SYNC_LAST  = 20,
    parameter int STB_AT     = 6,
    parameter int VIS_FIRST  = 128
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic              line_sync,
    output logic              vadv_stb,
    output logic              vis_win,
    output logic [ADDR_W-1:0] pix_addr
);
    import hline_pkg::*;

    localparam int VIS_LAST = VIS_FIRST + (2 ** ADDR_W) - 1;

    logic [CNT_W-1:0] cnt;
    line_flags_t      flags;

    hline_counter #(.CNT_W(CNT_W), .LINE_LEN(LINE_LEN)) u_cnt (
        .clk(clk), .rst_n(rst_n), .cnt(cnt)
    );

    hline_window #(.CNT_W(CNT_W), .FIRST(SYNC_FIRST), .LAST(SYNC_LAST)) u_sync (
        .clk(clk), .rst_n(rst_n), .cnt(cnt), .hit(flags.sync)
    );

    hline_window #(.CNT_W(CNT_W), .FIRST(STB_AT), .LAST(STB_AT)) u_stb (
        .clk(clk), .rst_n(rst_n), .cnt(cnt), .hit(flags.stb)
    );

    hline_window #(.CNT_W(CNT_W), .FIRST(VIS_FIRST), .LAST(VIS_LAST)) u_vis (
        .clk(clk), .rst_n(rst_n), .cnt(cnt), .hit(flags.vis)
    );

    // Drive the ports from the decoded flags and the low count bits
    always_comb begin
        line_sync = flags.sync;
        vadv_stb  = flags.stb;
        vis_win   = flags.vis;
        pix_addr  = cnt[ADDR_W-1:0];
    end

    AST_STB_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        vadv_stb |=> !vadv_stb); // R4
    AST_STB_IN_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
        vadv_stb |-> line_sync); // R7
    AST_ADDR_AT_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(vis_win) |-> (pix_addr == '0)); // R6
    AST_ADDR_AT_CLOSE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(vis_win) |-> ($past(pix_addr) == '1)); // R6

endmodule

// File: tb/hline_timing_tb.sv
`timescale 1ns/1ps
module hline_timing_tb_top;

    localparam int CLK_PERIOD = 100;
    localparam int LINE       = 300;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       line_sync, vadv_stb, vis_win;
    logic [6:0] pix_addr;

    int n_checks = 0;
    int n_fails  = 0;
    int model_cnt = 0;
    int cycles = 0;

    hline_timing dut_i (
        .clk(clk), .rst_n(rst_n), .line_sync(line_sync),
        .vadv_stb(vadv_stb), .vis_win(vis_win), .pix_addr(pix_addr)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Expected line position, derived from R1 and R2
    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (!rst_n) model_cnt <= 0;
        else if (model_cnt == LINE - 1) model_cnt <= 0;
        else model_cnt <= model_cnt + 1;
    end

    task automatic check(input string req, input int act, input int exp_v);
        n_checks++;
        if (act != exp_v) begin
            n_fails++;
            $display("FAIL %s at t=%0t: actual %0d expected %0d", req, $time, act, exp_v);
        end
    endtask

    // R2: outputs quiet and address zero while reset is held
    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check("R2 sync in reset", int'(line_sync), 0);
        check("R2 stb in reset", int'(vadv_stb), 0);
        check("R2 vis in reset", int'(vis_win), 0);
        check("R2 addr in reset", int'(pix_addr), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R2 first count after release", int'(pix_addr), 1);
        check("R2 sync right after release", int'(line_sync), 1);
    endtask

    // R1 R3 R4 R5 R6: per-clock decode and per-line pulse counts
    task automatic t_full_lines(input int lines);
        int prev_rise = -1;
        for (int l = 0; l < lines; l++) begin
            int n_sync = 0, n_stb = 0, n_vis = 0;
            for (int k = 0; k < LINE; k++) begin
                int c;
                logic ps;
                ps = line_sync;
                @(negedge clk);
                c = model_cnt;
                check("R3 sync decode", int'(line_sync), int'(c >= 1 && c <= 20));
                check("R4 strobe decode", int'(vadv_stb), int'(c == 6));
                check("R5 window decode", int'(vis_win), int'(c >= 128 && c <= 255));
                check("R6 address bits", int'(pix_addr), c % 128);
                if (vis_win && c == 128) check("R6 address at open", int'(pix_addr), 0);
                if (vis_win && c == 255) check("R6 address at close", int'(pix_addr), 127);
                n_sync += int'(line_sync);
                n_stb  += int'(vadv_stb);
                n_vis  += int'(vis_win);
                if (line_sync && !ps) begin
                    if (prev_rise >= 0) check("R1 sync period", cycles - prev_rise, LINE);
                    prev_rise = cycles;
                end
            end
            check("R3 sync width", n_sync, 20);
            check("R4 strobes per line", n_stb, 1);
            check("R5 window width", n_vis, 128);
        end
    endtask

    // R7: sync and strobe fall in the same clock
    task automatic t_overlap();
        do @(negedge clk); while (model_cnt != 5);
        check("R7 strobe low before", int'(vadv_stb), 0);
        @(negedge clk);
        check("R7 sync during strobe", int'(line_sync), 1);
        check("R7 strobe at count 6", int'(vadv_stb), 1);
        @(negedge clk);
        check("R7 strobe low after", int'(vadv_stb), 0);
        check("R7 sync still high", int'(line_sync), 1);
    endtask

    // R2: reset inside the visible window restarts the line
    task automatic t_mid_reset();
        do @(negedge clk); while (model_cnt != 150);
        check("R2 window open before reset", int'(vis_win), 1);
        rst_n = 1'b0;
        @(negedge clk);
        check("R2 window closed by reset", int'(vis_win), 0);
        check("R2 addr cleared", int'(pix_addr), 0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R2 sync after restart", int'(line_sync), 1);
        check("R2 addr after restart", int'(pix_addr), 1);
        repeat (5) @(negedge clk);
        check("R2 strobe after restart", int'(vadv_stb), 1);
    endtask

    initial begin
        t_reset();
        t_full_lines(3);
        t_overlap();
        t_mid_reset();
        t_full_lines(2);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check
    initial begin
        #(CLK_PERIOD * 20000);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

endmodule